// File: doc/BRIEF.md
# Unrolled Non-Restoring Array Divider

This block divides a 15-bit unsigned dividend by an 11-bit unsigned divisor and returns a 15-bit quotient and an 11-bit remainder. There is no clock and no iteration inside it. The division is laid out as fifteen add/subtract rows, one for each quotient bit and in order from the most significant dividend bit down. A partial remainder passes from one row to the next. The rows are packed into five identical groups of three. One last stage only corrects the remainder.

Each row reports its 12-bit partial remainder on a diagnostic bus, so a single row or group can be examined on its own. The block has no error signal. A zero divisor gives whatever the array produces for it, and the requirements pin that result down exactly. The block sits between registers chosen by the user, who must allow for the ripple through all fifteen rows when setting timing.

Top module: `nr_array_divider`

## Requirements
- R1: For any divisor other than zero, quotient × divisor + remainder equals the dividend and the quotient is the truncated integer quotient. Examples: 0xC71 ÷ 0x439 gives 0x2 remainder 0x3FF, 0x7FB8 ÷ 0x4E7 gives 0x1A remainder 0x42, and 0x6DB6 ÷ 1 gives 0x6DB6 remainder 0.
- R2: For any divisor other than zero, the remainder is strictly less than the divisor.
- R3: Row k (k = 0..14) uses dividend bit 14−k and drives `row_taps[12k+11:12k]`. Bit 11 of that field is the sign and bits 10:0 are the partial remainder. Let P = dividend >> (14−k). For a divisor D other than zero, the field modulo 4096 is P mod D when bit ((P / D) & 1) is 1, and (P mod D) − D otherwise.
- R4: Quotient bit 14−k is the inverse of the sign bit of row k.
- R5: Row 0 always subtracts. Its field equals (dividend[14] − divisor) modulo 4096, whatever the divisor is.
- R6: The final stage takes the row 14 field. If its sign is clear, bits 10:0 pass to the remainder unchanged. If its sign is set, the remainder is the low 11 bits of that field plus the divisor.
- R7: With a zero divisor, the quotient is {11 ones, inverted dividend[14:11]}, the remainder is dividend[10:0], and row k holds (dividend >> (14−k)) modulo 4096. Nothing else is signalled.
- R8: The outputs depend only on the present inputs. A change of input shows up at the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dividend | input | 15 | Unsigned dividend |
| divisor | input | 11 | Unsigned divisor; zero is allowed |
| quotient | output | 15 | Unsigned quotient |
| remainder | output | 11 | Corrected remainder |
| row_taps | output | 180 | Fifteen 12-bit row fields; row k sits at bits 12k+11:12k, with bit 11 of each field as its sign |

## Verification
The checker takes each input vector as held steady while its properties are tested. Properties that need a divisor other than zero are skipped when the divisor is zero. Random vectors come from a fixed seed and cover the full dividend range. The divisor is sometimes forced to zero, to one or to its largest value, so every divisor class is tested. Directed vectors add the three sample divisions, the largest dividend, and operands that make the last row go negative.

// File: rtl/nr_div_pkg.sv
package nr_div_pkg;
  localparam int DVD_W_DEF = 15;
  localparam int DVS_W_DEF = 11;
  localparam int ROWS_PER_GRP_DEF = 3;

  typedef enum logic {
    OP_SUB = 1'b0,
    OP_ADD = 1'b1
  } row_op_e;
endpackage

// File: rtl/nr_div_row.sv
module nr_div_row
  import nr_div_pkg::*;
#(
  parameter int DVS_W = DVS_W_DEF,
  localparam int PR_W = DVS_W + 1
) (
  input  logic [PR_W-1:0]  pr_in,
  input  logic             dvd_bit,
  input  logic [DVS_W-1:0] divisor,
  output logic [PR_W-1:0]  pr_out,
  output logic             q_bit
);
  // Shift in one dividend bit, then add or subtract the divisor.
  // The arithmetic wraps modulo 2^PR_W, which is safe because the result lies in [-D, D).
  function automatic logic [PR_W-1:0] step(input logic [PR_W-1:0] p,
                                           input logic b,
                                           input logic [DVS_W-1:0] d,
                                           input row_op_e op);
    logic [PR_W-1:0] shifted;
    logic [PR_W-1:0] ext;
    shifted = {p[PR_W-2:0], b};
    ext     = {1'b0, d};
    return (op == OP_ADD) ? shifted + ext : shifted - ext;
  endfunction

  row_op_e op;
  assign op     = pr_in[PR_W-1] ? OP_ADD : OP_SUB;
  assign pr_out = step(pr_in, dvd_bit, divisor, op);
  assign q_bit  = ~pr_out[PR_W-1];
endmodule

// File: rtl/nr_div_group.sv
module nr_div_group
  import nr_div_pkg::*;
#(
  parameter int DVS_W = DVS_W_DEF,
  parameter int ROWS  = ROWS_PER_GRP_DEF,
  localparam int PR_W = DVS_W + 1
) (
  input  logic [PR_W-1:0]      pr_in,
  input  logic [ROWS-1:0]      dvd_bits,  // MSB is used by the first row
  input  logic [DVS_W-1:0]     divisor,
  output logic [PR_W-1:0]      pr_out,
  output logic [ROWS*PR_W-1:0] taps,      // row r at [r*PR_W +: PR_W]
  output logic [ROWS-1:0]      q_bits     // MSB from the first row
);
  logic [PR_W-1:0] chain [0:ROWS];
  assign chain[0] = pr_in;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    nr_div_row #(.DVS_W(DVS_W)) u_row (
      .pr_in   (chain[r]),
      .dvd_bit (dvd_bits[ROWS-1-r]),
      .divisor (divisor),
      .pr_out  (chain[r+1]),
      .q_bit   (q_bits[ROWS-1-r])
    );
    assign taps[r*PR_W +: PR_W] = chain[r+1];
  end

  assign pr_out = chain[ROWS];
endmodule

// File: rtl/nr_div_fixup.sv
module nr_div_fixup
  import nr_div_pkg::*;
#(
  parameter int DVS_W = DVS_W_DEF,
  localparam int PR_W = DVS_W + 1
) (
  input  logic [PR_W-1:0]  pr_last,
  input  logic [DVS_W-1:0] divisor,
  output logic [DVS_W-1:0] remainder
);
  // Add the divisor back only when the last partial remainder is negative.
  function automatic logic [DVS_W-1:0] correct(input logic [PR_W-1:0] p,
                                               input logic [DVS_W-1:0] d);
    logic [PR_W-1:0] sum;
    sum = p + {1'b0, d};
    return p[PR_W-1] ? sum[DVS_W-1:0] : p[DVS_W-1:0];
  endfunction

  assign remainder = correct(pr_last, divisor);
endmodule

// File: rtl/nr_array_divider.sv
module nr_array_divider
  import nr_div_pkg::*;
#(
  parameter int DVD_W = DVD_W_DEF,
  parameter int DVS_W = DVS_W_DEF,
  parameter int ROWS_PER_GRP = ROWS_PER_GRP_DEF,
  localparam int PR_W   = DVS_W + 1,
  localparam int GROUPS = DVD_W / ROWS_PER_GRP,
  localparam int GRP_TAP_W = ROWS_PER_GRP * PR_W
) (
  input  logic [DVD_W-1:0]      dividend,
  input  logic [DVS_W-1:0]      divisor,
  output logic [DVD_W-1:0]      quotient,
  output logic [DVS_W-1:0]      remainder,
  output logic [DVD_W*PR_W-1:0] row_taps
);
  logic [PR_W-1:0] grp_chain [0:GROUPS];
  assign grp_chain[0] = '0;  // starts non-negative, so row 0 subtracts

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    nr_div_group #(.DVS_W(DVS_W), .ROWS(ROWS_PER_GRP)) u_grp (
      .pr_in    (grp_chain[g]),
      .dvd_bits (dividend[DVD_W-1-g*ROWS_PER_GRP -: ROWS_PER_GRP]),
      .divisor  (divisor),
      .pr_out   (grp_chain[g+1]),
      .taps     (row_taps[g*GRP_TAP_W +: GRP_TAP_W]),
      .q_bits   (quotient[DVD_W-1-g*ROWS_PER_GRP -: ROWS_PER_GRP])
    );
  end

  nr_div_fixup #(.DVS_W(DVS_W)) u_fix (
    .pr_last   (grp_chain[GROUPS]),
    .divisor   (divisor),
    .remainder (remainder)
  );
endmodule

// File: rtl/nr_div_checker.sv
module nr_div_checker #(
  parameter int DVD_W = 15,
  parameter int DVS_W = 11,
  localparam int PR_W = DVS_W + 1
) (
  input logic [DVD_W-1:0]      dividend,
  input logic [DVS_W-1:0]      divisor,
  input logic [DVD_W-1:0]      quotient,
  input logic [DVS_W-1:0]      remainder,
  input logic [DVD_W*PR_W-1:0] row_taps
);
  logic known;
  assign known = !$isunknown({dividend, divisor, quotient, remainder, row_taps});

  always_comb begin
    if (known) begin
      if (divisor != '0) begin
        p_identity_r1: assert (int'(quotient) * int'(divisor) + int'(remainder) == int'(dividend))
          else $error("R1 identity broken");
        p_rem_below_r2: assert (remainder < divisor)
          else $error("R2 remainder not below divisor");
      end
      p_fix_r6: assert (remainder == (row_taps[DVD_W*PR_W-1]
                          ? DVS_W'(row_taps[(DVD_W-1)*PR_W +: DVS_W] + divisor)
                          : row_taps[(DVD_W-1)*PR_W +: DVS_W]))
        else $error("R6 remainder fixup wrong");
      p_first_sub_r5: assert (row_taps[PR_W-1:0] ==
                              PR_W'({{(PR_W-1){1'b0}}, dividend[DVD_W-1]} - {1'b0, divisor}))
        else $error("R5 first row did not subtract");
    end
  end

  for (genvar k = 0; k < DVD_W; k++) begin : g_rowchk
    logic [PR_W-1:0] t;
    assign t = row_taps[k*PR_W +: PR_W];
    always_comb begin
      if (known) begin
        p_qbit_sign_r4: assert (quotient[DVD_W-1-k] == ~t[PR_W-1])
          else $error("R4 quotient bit vs row sign");
        if (divisor != '0) begin
          p_row_range_r3: assert (t[PR_W-1] ? ({1'b0, t} + {2'b00, divisor} >= (PR_W+1)'(1 << PR_W))
                                            : (t[DVS_W-1:0] < divisor))
            else $error("R3 row partial remainder out of range");
        end
      end
    end
  end
endmodule

bind nr_array_divider nr_div_checker #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_nr_div_chk (
  .dividend  (dividend),
  .divisor   (divisor),
  .quotient  (quotient),
  .remainder (remainder),
  .row_taps  (row_taps)
);

// File: tb/test_nr_array_divider.sv
module test_nr_array_divider;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 15;
  localparam int DW = 11;
  localparam int PW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NW-1:0]    dividend = '0;
  logic [DW-1:0]    divisor = '0;
  logic [NW-1:0]    quotient;
  logic [DW-1:0]    remainder;
  logic [NW*PW-1:0] row_taps;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nr_array_divider i_nr_array_divider (
    .dividend (dividend), .divisor (divisor),
    .quotient (quotient), .remainder (remainder), .row_taps (row_taps)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s n=%h d=%h actual=%h expected=%h", req, dividend, divisor, act, exp);
    end
  endtask

  function automatic int exp_quot(input int n, input int d);
    if (d == 0) return 32'h7FF0 | ((~(n >> 11)) & 4'hF);
    return n / d;
  endfunction

  function automatic int exp_rem(input int n, input int d);
    if (d == 0) return n & 12'h7FF;
    return n % d;
  endfunction

  function automatic int exp_tap(input int n, input int d, input int k);
    int p, m;
    p = n >> (NW-1-k);
    if (d == 0) return p & 12'hFFF;
    m = p % d;
    return (((p / d) & 1) != 0) ? m : ((m - d) & 12'hFFF);
  endfunction

  task automatic apply(input int n, input int d);
    @(negedge clk);
    dividend = NW'(n);
    divisor  = DW'(d);
    #1;  // no clock edge needed: purely combinational (R8)
    if (d == 0) begin
      check("R7 quotient", int'(quotient), exp_quot(n, d));
      check("R7 remainder", int'(remainder), exp_rem(n, d));
    end else begin
      check("R1 quotient", int'(quotient), exp_quot(n, d));
      check("R1 remainder", int'(remainder), exp_rem(n, d));
      check("R2 rem<div", int'(remainder < divisor), 1);
    end
    check("R5 row0", int'(row_taps[PW-1:0]), ((n >> (NW-1)) - d) & 12'hFFF);
    for (int k = 0; k < NW; k++) begin
      check("R3 row tap", int'(row_taps[k*PW +: PW]), exp_tap(n, d, k));
      check("R4 qbit", int'(quotient[NW-1-k]), int'(~row_taps[k*PW+PW-1]) & 1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // Starting state: with all-zero inputs, R7 gives quotient 0x7FFF and remainder 0
    #1;
    check("R7 idle quotient", int'(quotient), 32'h7FFF);
    check("R7 idle remainder", int'(remainder), 0);
    // R1 sample divisions
    apply(32'hC71, 32'h439);
    check("R1 C71/439 q", int'(quotient), 2);
    check("R1 C71/439 r", int'(remainder), 32'h3FF);
    apply(32'h7FB8, 32'h4E7);
    check("R1 7FB8/4E7 q", int'(quotient), 32'h1A);
    check("R1 7FB8/4E7 r", int'(remainder), 32'h42);
    apply(32'h6DB6, 1);
    check("R1 6DB6/1 q", int'(quotient), 32'h6DB6);
    check("R1 6DB6/1 r", int'(remainder), 0);
    // Corner cases: largest operands, a last row that goes negative (R6), zero divisor (R7)
    apply(32'h7FFF, 32'h7FF);
    apply(32'h7FFF, 1);
    apply(0, 32'h7FF);
    apply(32'h7FE, 32'h7FF);
    apply(5, 3);
    apply(32'h7FFF, 0);
    apply(32'h7FB8, 0);
    apply(32'h0800, 0);
    // R8: a change of input alone changes the outputs
    dividend = 15'd100; divisor = 11'd7; #1;
    check("R8 comb q", int'(quotient), 14);
    dividend = 15'd99; #1;
    check("R8 comb r", int'(remainder), 1);
    // Random mix
    for (int i = 0; i < 400; i++) begin
      int n, d, sel;
      n = int'($urandom & 32'h7FFF);
      sel = int'($urandom % 8);
      case (sel)
        0: d = 0;
        1: d = 1;
        2: d = 32'h7FF;
        default: d = int'($urandom & 32'h7FF);
      endcase
      apply(n, d);
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule